// File: doc/BRIEF.md
# Sample-Rate Frame Pulse Generator

This block produces the frame output of one serial input channel. In self-timed operation it issues a data-request pulse once per input sample period. The sample period is given as a count of system clocks (the interpolation factor). The serial clock period is given as a count of system clocks too. Because the sample period need not be a whole number of serial clock cycles, a phase accumulator decides, at each serial clock edge, whether the request falls in that serial cycle. Successive request intervals therefore differ by one serial cycle, and their average equals the sample period.

The block can instead forward an external frame source: either the frame input pin or the frame-end signal of the preceding channel. A word tracker follows each frame start and marks the serial cycle that carries the last bit of the word. This frame-end marker can replace the request on the frame output, so that channels and devices can be chained. Sleep and channel reset silence all outputs. After both are released, the first frame waits for a programmable number of serial clock edges.

The control state machine has three states. ST_OFF is entered from any state when sleep or channel reset is high. OFF→HOLD happens on the first clock with both released. HOLD→RUN happens on the serial edge at which the hold-off count equals the programmed latency. That edge is also frame slot 0. RUN→OFF happens on sleep or channel reset.

Top module: `frame_pulse_gen`

## Requirements
- R1: frame_start rises and falls only on system clock edges where sclk_rise is high. A request therefore lasts exactly one serial cycle, from one strobe to the next.
- R2: In self mode (ext_mode=0), let strobes after release be numbered n=0,1,… and let L be reset_lat. A request appears after strobe n when n=L, or when n>L and floor(m·sclk_per/interp) differs from floor((m-1)·sclk_per/interp), with m=n-L.
- R3: When interp is not a multiple of sclk_per, request intervals alternate between the floor and the ceiling of interp/sclk_per serial cycles. The internal phase stays below interp while running.
- R4: No request appears on strobes 0 to L-1 after release. The first request follows strobe L.
- R5: In external mode (ext_mode=1), frame_start after each strobe equals the selected source sampled at that strobe. ext_src=0 selects frame_pin and ext_src=1 selects prev_frame_end. The unselected input has no effect.
- R6: frame_end is high for exactly the one serial cycle following strobe s+WORD_BITS, where s is a strobe after which frame_start was high. This is the cycle of the word's last bit.
- R7: frame_out equals frame_start when out_sel_end=0 and frame_end when out_sel_end=1.
- R8: While sleep is high, frame_out, frame_start and frame_end are low in the same cycle, strobes included. Leaving sleep restarts the latency count of R4.
- R9: While chan_reset is high, all outputs are low from the next clock. Releasing it restarts the latency count of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_rise | input | 1 | One-clock strobe at each serial clock launch edge |
| sleep | input | 1 | Channel sleep |
| chan_reset | input | 1 | Channel reset, held high while in reset |
| interp | input | PER_W | Input sample period in system clocks |
| sclk_per | input | PER_W | Serial clock period in system clocks |
| reset_lat | input | LAT_W | Serial edges to wait before the first frame |
| ext_mode | input | 1 | 0 self-timed, 1 external framing |
| ext_src | input | 1 | External source: 0 pin, 1 previous channel |
| out_sel_end | input | 1 | frame_out carries 0 request, 1 frame end |
| frame_pin | input | 1 | External frame input pin |
| prev_frame_end | input | 1 | Frame-end signal of the previous channel |
| frame_out | output | 1 | Frame output |
| frame_start | output | 1 | Internal frame start, one serial cycle |
| frame_end | output | 1 | Last-bit marker, one serial cycle |

## Verification
The assertions check four things on every cycle. Outputs are quiet in sleep and after channel reset. frame_start and frame_end change only on strobes. The phase accumulator stays bounded while running. External-mode starts copy the selected source. The exact request positions, the floor/ceiling alternation of the intervals, the latency count and the placement of the frame-end marker WORD_BITS strobes later depend on counting strobes across many serial cycles. Only the bench's scenarios show those, and they compare the outputs against a closed-form slot formula.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } fpg_state_e;
endpackage

// File: rtl/fpg_phase_acc.sv
// Phase accumulator: adds the serial period on each step, wraps at the sample period.
module fpg_phase_acc #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] incr,
    output logic             hit,
    output logic [PER_W-1:0] phase
);
    logic [PER_W:0] sum;
    logic [PER_W:0] wrapped;

    always_comb begin
        sum     = {1'b0, phase} + {1'b0, incr};
        hit     = (sum >= {1'b0, period});
        wrapped = sum - {1'b0, period};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (step) begin
            phase <= hit ? wrapped[PER_W-1:0] : sum[PER_W-1:0];
        end
    end
endmodule

// File: rtl/fpg_holdoff.sv
// Counts serial edges after release until the programmed latency is reached.
module fpg_holdoff #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LAT_W-1:0] limit,
    output logic             done
);
    logic [LAT_W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fpg_word_track.sv
// Follows a word after each frame start and flags the serial cycle of its last bit.
module fpg_word_track #(
    parameter int WORD_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic start,
    output logic last
);
    localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

    logic [CNT_W-1:0] bit_idx;
    logic             busy;

    assign last = busy && (bit_idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (clear) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (step) begin
            if (start) begin
                busy    <= 1'b1;
                bit_idx <= '0;
            end else if (busy) begin
                if (bit_idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
    import fpg_pkg::*;
#(
    parameter int PER_W     = 12,
    parameter int LAT_W     = 8,
    parameter int WORD_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sleep,
    input  logic             chan_reset,
    input  logic [PER_W-1:0] interp,
    input  logic [PER_W-1:0] sclk_per,
    input  logic [LAT_W-1:0] reset_lat,
    input  logic             ext_mode,
    input  logic             ext_src,
    input  logic             out_sel_end,
    input  logic             frame_pin,
    input  logic             prev_frame_end,
    output logic             frame_out,
    output logic             frame_start,
    output logic             frame_end
);
    fpg_state_e       state_q, state_nx;
    logic             active;
    logic             ext_bit;
    logic             acc_hit;
    logic [PER_W-1:0] acc_val;
    logic             hold_done;
    logic             word_last;
    logic             req_q;

    assign active  = !sleep && !chan_reset;
    assign ext_bit = ext_src ? prev_frame_end : frame_pin;

    fpg_phase_acc #(.PER_W(PER_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_RUN),
        .step   (sclk_rise && active && !ext_mode && state_q == ST_RUN),
        .period (interp),
        .incr   (sclk_per),
        .hit    (acc_hit),
        .phase  (acc_val)
    );

    fpg_holdoff #(.LAT_W(LAT_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_HOLD),
        .step  (sclk_rise && state_q == ST_HOLD),
        .limit (reset_lat),
        .done  (hold_done)
    );

    fpg_word_track #(.WORD_BITS(WORD_BITS)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!active || state_q == ST_OFF),
        .step  (sclk_rise),
        .start (req_q),
        .last  (word_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:  if (active) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (!active)                     state_nx = ST_OFF;
                else if (sclk_rise && hold_done) state_nx = ST_RUN;
            end
            ST_RUN:  if (!active) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    // Frame slot register, updated once per serial edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (!active || state_q == ST_OFF) begin
            req_q <= 1'b0;
        end else if (sclk_rise) begin
            unique case (state_q)
                ST_HOLD: req_q <= hold_done ? (ext_mode ? ext_bit : 1'b1) : 1'b0;
                ST_RUN:  req_q <= ext_mode ? ext_bit : acc_hit;
                default: req_q <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        frame_start = active && req_q;
        frame_end   = active && word_last;
        frame_out   = out_sel_end ? frame_end : frame_start;
    end
endmodule

// File: rtl/frame_pulse_gen_chk.sv
module frame_pulse_gen_chk
    import fpg_pkg::*;
#(
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_rise,
    input logic             sleep,
    input logic             chan_reset,
    input logic [PER_W-1:0] interp,
    input logic [PER_W-1:0] sclk_per,
    input logic             ext_mode,
    input logic             ext_src,
    input logic             frame_pin,
    input logic             prev_frame_end,
    input logic             frame_out,
    input logic             frame_start,
    input logic             frame_end,
    input fpg_state_e       state_q,
    input logic [PER_W-1:0] acc_val
);
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!frame_out && !frame_start && !frame_end)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset |=> (!frame_start && !frame_end)); // R9

    AST_START_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !sleep && !chan_reset) ##1 (!sleep && !chan_reset) |-> $stable(frame_start)); // R1

    AST_END_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !sleep && !chan_reset) ##1 (!sleep && !chan_reset) |-> $stable(frame_end)); // R6

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sclk_per <= interp) |-> (acc_val < interp)); // R3

    AST_EXT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && ext_mode && !ext_src && state_q == ST_RUN && !sleep && !chan_reset)
        ##1 (!sleep && !chan_reset) |-> (frame_start == $past(frame_pin))); // R5

    AST_EXT_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && ext_mode && ext_src && state_q == ST_RUN && !sleep && !chan_reset)
        ##1 (!sleep && !chan_reset) |-> (frame_start == $past(prev_frame_end))); // R5
endmodule

bind frame_pulse_gen frame_pulse_gen_chk #(.PER_W(PER_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk_rise      (sclk_rise),
    .sleep          (sleep),
    .chan_reset     (chan_reset),
    .interp         (interp),
    .sclk_per       (sclk_per),
    .ext_mode       (ext_mode),
    .ext_src        (ext_src),
    .frame_pin      (frame_pin),
    .prev_frame_end (prev_frame_end),
    .frame_out      (frame_out),
    .frame_start    (frame_start),
    .frame_end      (frame_end),
    .state_q        (state_q),
    .acc_val        (acc_val)
);

// File: tb/frame_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module frame_pulse_gen_tb_top;
    localparam int PER_W = 12;
    localparam int LAT_W = 8;
    localparam int WORD  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sclk_rise = 1'b0;
    logic             sleep = 1'b0;
    logic             chan_reset = 1'b1;
    logic [PER_W-1:0] interp = 12'd66;
    logic [PER_W-1:0] sclk_per = 12'd2;
    logic [LAT_W-1:0] reset_lat = '0;
    logic             ext_mode = 1'b0;
    logic             ext_src = 1'b0;
    logic             out_sel_end = 1'b0;
    logic             frame_pin = 1'b0;
    logic             prev_frame_end = 1'b0;
    logic             frame_out, frame_start, frame_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    frame_pulse_gen #(.PER_W(PER_W), .LAT_W(LAT_W), .WORD_BITS(WORD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sleep(sleep),
        .chan_reset(chan_reset), .interp(interp), .sclk_per(sclk_per),
        .reset_lat(reset_lat), .ext_mode(ext_mode), .ext_src(ext_src),
        .out_sel_end(out_sel_end), .frame_pin(frame_pin),
        .prev_frame_end(prev_frame_end), .frame_out(frame_out),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    task automatic check(string req, int n, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s strobe %0d: actual %b expected %b", req, n, act, exp);
        end
    endtask

    // Closed-form request slot for self mode (R2, R3, R4)
    function automatic bit exp_self(int n, int lat, int per, int ip);
        int m;
        if (n < lat) return 1'b0;
        if (n == lat) return 1'b1;
        m = n - lat;
        return ((m * per) / ip) != (((m - 1) * per) / ip);
    endfunction

    function automatic bit ext_slot(int n);
        return (n == 3) || (n == 3 + WORD + 5) || (n == 3 + 2 * WORD + 11);
    endfunction

    // Hold a blocker for a few serial cycles with strobes, checking silence
    task automatic block_phase(bit use_sleep, int per);
        @(negedge clk);
        if (use_sleep) sleep = 1'b1; else chan_reset = 1'b1;
        #0.5;
        if (use_sleep) check("R8", -1, frame_out | frame_start | frame_end, 1'b0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            sclk_rise = 1'b1;
            @(negedge clk);
            sclk_rise = 1'b0;
            check(use_sleep ? "R8" : "R9", -1, frame_out | frame_start | frame_end, 1'b0);
            repeat (per - 1) @(negedge clk);
        end
    endtask

    task automatic release_all();
        sleep = 1'b0;
        chan_reset = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_self(int lat, int per, int ip, bit oend, bit use_sleep, bit sleep_mid);
        int nmax;
        string tag;
        block_phase(use_sleep, per);
        interp = PER_W'(ip); sclk_per = PER_W'(per); reset_lat = LAT_W'(lat);
        ext_mode = 1'b0; out_sel_end = oend;
        release_all();
        nmax = lat + 3 * (ip / per + 1) + WORD + 2;
        for (int n = 0; n < nmax; n++) begin
            sclk_rise = 1'b1;
            @(negedge clk);
            sclk_rise = 1'b0;
            tag = (n <= lat) ? "R4" : ((ip % per) != 0 ? "R3" : "R2");
            check(tag, n, frame_start, exp_self(n, lat, per, ip));
            check("R6", n, frame_end, (n >= WORD) ? exp_self(n - WORD, lat, per, ip) : 1'b0);
            check("R7", n, frame_out, oend ? frame_end : frame_start);
            if (sleep_mid && n == nmax - 3) begin
                sleep = 1'b1;
                #0.5;
                check("R8", n, frame_out | frame_start | frame_end, 1'b0);
                sleep = 1'b0;
                chan_reset = 1'b1;
                break;
            end
            repeat (per - 2) @(negedge clk);
        end
    endtask

    task automatic run_ext(bit src_sel, bit oend);
        int per;
        logic want;
        per = 3;
        block_phase(1'b0, per);
        sclk_per = PER_W'(per); reset_lat = '0;
        ext_mode = 1'b1; ext_src = src_sel; out_sel_end = oend;
        release_all();
        for (int n = 0; n < 3 * WORD + 24; n++) begin
            sclk_rise = 1'b1;
            if (src_sel) begin
                prev_frame_end = ext_slot(n);
                frame_pin = 1'($urandom);
            end else begin
                frame_pin = ext_slot(n);
                prev_frame_end = 1'($urandom);
            end
            @(negedge clk);
            sclk_rise = 1'b0;
            frame_pin = 1'b0;
            prev_frame_end = 1'b0;
            check("R5", n, frame_start, ext_slot(n));
            want = (n >= WORD) ? ext_slot(n - WORD) : 1'b0;
            check("R6", n, frame_end, want);
            check("R7", n, frame_out, oend ? want : ext_slot(n));
            repeat (per - 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, ip, lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9", -1, frame_out | frame_start | frame_end, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", -1, frame_out | frame_start | frame_end, 1'b0);

        // Directed corners
        run_self(0, 2, 66, 1'b0, 1'b0, 1'b0);   // integer ratio, zero latency
        run_self(5, 3, 100, 1'b1, 1'b0, 1'b0);  // fractional ratio, frame-end output
        run_self(2, 4, 134, 1'b0, 1'b0, 1'b1);  // sleep in the middle of a run
        run_self(7, 2, 67, 1'b0, 1'b1, 1'b0);   // leave sleep, latency restarts
        // Random self-timed cases
        for (int t = 0; t < 4; t++) begin
            per = 2 + int'($urandom % 3);
            ip  = per * (WORD + 1) + int'($urandom % (per * 10));
            lat = int'($urandom % 12);
            run_self(lat, per, ip, 1'($urandom), 1'($urandom), 1'b0);
        end
        // External framing from pin and from previous channel
        run_ext(1'b0, 1'b0);
        run_ext(1'b1, 1'b1);
        run_ext(1'b1, 1'b0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule